// File: doc/BRIEF.md
# Framed PCM Serial Port

This block is the synchronous voice-sample port of a telephone codec. An external bit clock and an 8 kHz frame sync arrive as plain inputs. They are oversampled by the block's own system clock. In every frame the port shifts one transmit sample out on a serial pin, with a separate output-enable that marks when the pin is driven. In the same frame it shifts one receive sample in from a second serial pin. Toward the codec core it takes a parallel transmit word. It returns the received word with a single-cycle strobe once the last bit of the slot has arrived.

Four modes are chosen by a two-bit field:
- `00`: companded 8-bit samples.
- `01`: 16-bit linear samples, of which 14 bits are significant.
- `10` and `11`: 8-bit companded samples placed in a fixed slot for channel A or channel B of an external transceiver.

In companded mode the block measures how long the sync stays high and chooses long-frame or short-frame timing from that width. In long-frame timing the last transmit bit is released early if the sync falls while that bit is on the pin. The companding law itself is handled by the core.

Top module: `pcm_serial_port`

## Requirements
- R1: After reset `tx_oe` and `rx_valid` are low. No slot is driven until the first frame start, which is a bit-clock rising edge with `fsync` high after a rising edge with `fsync` low.
- R2: A sync that is high for 2 or more bit-clock rising edges is classed as long-frame, and a sync high for exactly one rising edge is classed as short-frame. The class applies to the timing of the following frame. After reset the class is short-frame.
- R3: In companded mode (`mode_sel` = 00) with long-frame timing, `tx_sample[7:0]` is sent MSB first. The MSB appears on the frame-start rising edge and each later bit on the next rising edge, so eight rising edges carry the sample.
- R4: In companded mode with short-frame timing, the MSB of `tx_sample[7:0]` appears on the first rising edge after the frame-start edge, followed by the other seven bits on the next seven rising edges.
- R5: In long-frame companded timing, `tx_oe` drops at whichever comes first: the falling edge of `fsync` while the LSB is on the pin, or the ninth rising edge counted from the frame start.
- R6: In linear mode (`mode_sel` = 01), 16 bit times start on the first rising edge after the frame-start edge, whatever the detected frame class. `tx_sample[15:2]` is sent MSB first, followed by two 0 bits. The received word is reported with bits [1:0] forced to 0.
- R7: In modes 10 and 11, eight companded bits start on rising edge number 1 + 8*S after the frame-start edge. S is `CHA_SLOT` (default 2) for mode 10 and `CHB_SLOT` (default 3) for mode 11. The sample is `tx_sample[7:0]`.
- R8: `tx_oe` is low on every bit time outside the active slot. `tx_data` and `tx_oe` only change on a bit-clock rising edge, or when the release of R5 applies.
- R9: `rx_in` is sampled on each bit-clock falling edge inside the slot. One cycle after the falling edge of the last slot bit, `rx_valid` is high for exactly one cycle, once per frame. An 8-bit sample is returned in `rx_sample[7:0]` with bits [15:8] at 0.
- R10: `tx_sample` and `mode_sel` are captured on the frame-start edge. Changing either later in the frame has no effect on that frame's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk | input | 1 | External bit clock |
| fsync | input | 1 | 8 kHz frame sync |
| mode_sel | input | 2 | Port mode: 00 companded, 01 linear, 10 channel A slot, 11 channel B slot |
| tx_sample | input | 16 | Parallel transmit word from the core |
| rx_in | input | 1 | Serial receive data |
| tx_data | output | 1 | Serial transmit data |
| tx_oe | output | 1 | High while the transmit pin is driven |
| rx_sample | output | 16 | Received word |
| rx_valid | output | 1 | One-cycle strobe marking a new `rx_sample` |

## Verification
Two events can meet in one system-clock cycle: the sync falling and the ninth bit-clock rising edge of a long frame. Both of them end the LSB drive. The bench provokes this by lowering `fsync` in the same cycle as that rising edge. It expects the enable to be low right after that edge, which is the same result as a separate early fall during the LSB's low phase, where the enable must already drop before the ninth edge. A second meeting, between a new frame start and the frame-class update, is covered by changing the sync width from frame to frame and checking that each new width only shapes the frame after it.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

    typedef enum logic [1:0] {
        PM_COMP = 2'b00,
        PM_LIN  = 2'b01,
        PM_CHA  = 2'b10,
        PM_CHB  = 2'b11
    } pcm_mode_e;

    localparam int SAMPLE_W = 16;
    localparam int COMP_W   = 8;
    localparam int LIN_SIG  = 14;
    localparam int IDX_W    = $clog2(SAMPLE_W);
    localparam int NIDX_W   = $clog2(COMP_W);

    typedef struct packed {
        logic             active;
        logic             last;
        logic             wide;
        logic [IDX_W-1:0] idx;
    } slot_pos_t;

    function automatic logic pick_bit(input logic [SAMPLE_W-1:0] w,
                                      input logic [IDX_W-1:0]    idx,
                                      input logic                wide);
        if (wide)
            return (idx < IDX_W'(LIN_SIG)) ? w[SAMPLE_W-1-int'(idx)] : 1'b0;
        else
            return w[COMP_W-1-int'(idx[NIDX_W-1:0])];
    endfunction

endpackage

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer
    import pcm_port_pkg::*;
#(
    parameter int KW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bclk,
    input  logic          fsync,
    input  pcm_mode_e     mode_in,
    output logic          rise,
    output logic          fall,
    output logic          fs_fall,
    output logic          frame_start,
    output logic [KW-1:0] k_now,
    output pcm_mode_e     mode_eff,
    output logic          long_eff
);
    localparam logic [KW-1:0] K_MAX = '1;

    logic          bclk_q;
    logic          fs_q;
    logic          fs_last;
    logic [1:0]    hi_cnt;
    logic          long_det;
    logic          long_f;
    logic [KW-1:0] pos;
    pcm_mode_e     mode_f;

    assign rise        = bclk & ~bclk_q;
    assign fall        = ~bclk & bclk_q;
    assign fs_fall     = fs_q & ~fsync;
    assign frame_start = rise & fsync & ~fs_last;
    assign k_now       = frame_start ? '0 : ((pos == K_MAX) ? pos : pos + KW'(1));
    assign mode_eff    = frame_start ? mode_in : mode_f;
    assign long_eff    = frame_start ? long_det : long_f;

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_q   <= 1'b0;
            fs_q     <= 1'b0;
            fs_last  <= 1'b0;
            hi_cnt   <= 2'd0;
            long_det <= 1'b0;
            long_f   <= 1'b0;
            pos      <= K_MAX;
            mode_f   <= PM_COMP;
        end else begin
            bclk_q <= bclk;
            fs_q   <= fsync;
            if (rise) begin
                fs_last <= fsync;
                pos     <= k_now;
                if (fsync)
                    hi_cnt <= frame_start ? 2'd1 : ((hi_cnt == 2'd3) ? 2'd3 : hi_cnt + 2'd1);
                else if (fs_last)
                    long_det <= (hi_cnt >= 2'd2);
                if (frame_start) begin
                    mode_f <= mode_in;
                    long_f <= long_det;
                end
            end
        end
    end
endmodule

// File: rtl/pcm_slot_window.sv
module pcm_slot_window
    import pcm_port_pkg::*;
#(
    parameter int KW       = 9,
    parameter int CHA_SLOT = 2,
    parameter int CHB_SLOT = 3
) (
    input  logic [KW-1:0] k_now,
    input  pcm_mode_e     mode_eff,
    input  logic          long_eff,
    output slot_pos_t     sp
);
    localparam logic [KW-1:0] ST_CHA = KW'(1 + COMP_W * CHA_SLOT);
    localparam logic [KW-1:0] ST_CHB = KW'(1 + COMP_W * CHB_SLOT);

    logic [KW-1:0] start;
    logic [KW-1:0] len;
    logic [KW-1:0] off;

    always_comb begin
        unique case (mode_eff)
            PM_COMP: start = long_eff ? KW'(0) : KW'(1);
            PM_LIN:  start = KW'(1);
            PM_CHA:  start = ST_CHA;
            default: start = ST_CHB;
        endcase
        len       = (mode_eff == PM_LIN) ? KW'(SAMPLE_W) : KW'(COMP_W);
        off       = k_now - start;
        sp.active = (k_now >= start) && (off < len);
        sp.last   = (off == len - KW'(1));
        sp.wide   = (mode_eff == PM_LIN);
        sp.idx    = off[IDX_W-1:0];
    end
endmodule

// File: rtl/pcm_tx_drv.sv
module pcm_tx_drv
    import pcm_port_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                rise,
    input  logic                fs_fall,
    input  logic                frame_start,
    input  logic [SAMPLE_W-1:0] tx_sample,
    input  slot_pos_t           sp,
    input  pcm_mode_e           mode_eff,
    input  logic                long_eff,
    output logic                tx_data,
    output logic                tx_oe
);
    logic [SAMPLE_W-1:0] txbuf;
    logic [SAMPLE_W-1:0] word;
    logic                lsb_long;

    assign word = frame_start ? tx_sample : txbuf;

    always_ff @(posedge clk) begin
        if (rst) begin
            txbuf    <= '0;
            tx_data  <= 1'b0;
            tx_oe    <= 1'b0;
            lsb_long <= 1'b0;
        end else if (rise) begin
            if (frame_start)
                txbuf <= tx_sample;
            tx_oe    <= sp.active;
            tx_data  <= sp.active ? pick_bit(word, sp.idx, sp.wide) : 1'b0;
            lsb_long <= sp.active & sp.last & (mode_eff == PM_COMP) & long_eff;
        end else if (fs_fall && lsb_long && tx_oe) begin
            tx_oe <= 1'b0;
        end
    end
endmodule

// File: rtl/pcm_rx_cap.sv
module pcm_rx_cap
    import pcm_port_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                rise,
    input  logic                fall,
    input  logic                rx_in,
    input  logic                win_in,
    input  logic                last_in,
    input  logic                wide_in,
    output logic [SAMPLE_W-1:0] rx_sample,
    output logic                rx_valid
);
    logic                win;
    logic                last;
    logic                wide;
    logic [SAMPLE_W-1:0] sh;
    logic [SAMPLE_W-1:0] shifted;

    assign shifted = {sh[SAMPLE_W-2:0], rx_in};

    always_ff @(posedge clk) begin
        if (rst) begin
            win       <= 1'b0;
            last      <= 1'b0;
            wide      <= 1'b0;
            sh        <= '0;
            rx_sample <= '0;
            rx_valid  <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (rise) begin
                win  <= win_in;
                last <= last_in;
                wide <= wide_in;
            end else if (fall && win) begin
                sh  <= shifted;
                win <= 1'b0;
                if (last) begin
                    rx_valid  <= 1'b1;
                    rx_sample <= wide ? {shifted[SAMPLE_W-1:SAMPLE_W-LIN_SIG], (SAMPLE_W-LIN_SIG)'(0)}
                                      : {(SAMPLE_W-COMP_W)'(0), shifted[COMP_W-1:0]};
                end
            end
        end
    end
endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port
    import pcm_port_pkg::*;
#(
    parameter int FRAME_BITS = 256,
    parameter int CHA_SLOT   = 2,
    parameter int CHB_SLOT   = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bclk,
    input  logic        fsync,
    input  logic [1:0]  mode_sel,
    input  logic [15:0] tx_sample,
    input  logic        rx_in,
    output logic        tx_data,
    output logic        tx_oe,
    output logic [15:0] rx_sample,
    output logic        rx_valid
);
    localparam int KW = $clog2(FRAME_BITS) + 1;

    logic          rise;
    logic          fall;
    logic          fs_fall;
    logic          frame_start;
    logic [KW-1:0] k_now;
    pcm_mode_e     mode_eff;
    logic          long_eff;
    slot_pos_t     sp;

    pcm_frame_timer #(.KW(KW)) u_timer (
        .clk(clk), .rst(rst), .bclk(bclk), .fsync(fsync),
        .mode_in(pcm_mode_e'(mode_sel)),
        .rise(rise), .fall(fall), .fs_fall(fs_fall), .frame_start(frame_start),
        .k_now(k_now), .mode_eff(mode_eff), .long_eff(long_eff)
    );

    pcm_slot_window #(.KW(KW), .CHA_SLOT(CHA_SLOT), .CHB_SLOT(CHB_SLOT)) u_win (
        .k_now(k_now), .mode_eff(mode_eff), .long_eff(long_eff), .sp(sp)
    );

    pcm_tx_drv u_tx (
        .clk(clk), .rst(rst), .rise(rise), .fs_fall(fs_fall),
        .frame_start(frame_start), .tx_sample(tx_sample), .sp(sp),
        .mode_eff(mode_eff), .long_eff(long_eff),
        .tx_data(tx_data), .tx_oe(tx_oe)
    );

    pcm_rx_cap u_rx (
        .clk(clk), .rst(rst), .rise(rise), .fall(fall), .rx_in(rx_in),
        .win_in(sp.active), .last_in(sp.last), .wide_in(sp.wide),
        .rx_sample(rx_sample), .rx_valid(rx_valid)
    );
endmodule

// File: rtl/pcm_serial_port_chk.sv
module pcm_serial_port_chk (
    input logic        clk,
    input logic        rst,
    input logic        bclk,
    input logic        tx_oe,
    input logic        tx_data,
    input logic [15:0] rx_sample,
    input logic        rx_valid
);
    AST_OE_RISES_ON_BCLK_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_oe) |-> ($past(bclk) && !$past(bclk, 2)));  // R8
    AST_DATA_HOLDS_BETWEEN_RISES: assert property (@(posedge clk) disable iff (rst)
        !($past(bclk) && !$past(bclk, 2)) |-> $stable(tx_data));  // R8
    AST_STROBE_AFTER_BCLK_FALL: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> (!$past(bclk) && $past(bclk, 2)));  // R9
    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);  // R9
    AST_SAMPLE_FORMAT: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> (rx_sample[15:8] == 8'h00 || rx_sample[1:0] == 2'b00));  // R6
endmodule

bind pcm_serial_port pcm_serial_port_chk u_chk (
    .clk(clk), .rst(rst), .bclk(bclk), .tx_oe(tx_oe), .tx_data(tx_data),
    .rx_sample(rx_sample), .rx_valid(rx_valid)
);

// File: tb/pcm_serial_port_test.sv
module pcm_serial_port_test;
    localparam int CLK_PERIOD = 10;
    localparam int CHA = 2;
    localparam int CHB = 3;
    localparam int NK  = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bclk = 1'b0;
    logic        fsync = 1'b0;
    logic [1:0]  mode_sel = 2'b00;
    logic [15:0] tx_sample = '0;
    logic        rx_in = 1'b1;
    logic        tx_data;
    logic        tx_oe;
    logic [15:0] rx_sample;
    logic        rx_valid;

    int total = 0;
    int fails = 0;
    int pulses = 0;
    logic [15:0] got = '0;
    bit prev_long = 1'b0;
    bit done = 1'b0;

    pcm_serial_port #(.CHA_SLOT(CHA), .CHB_SLOT(CHB)) uut (
        .clk(clk), .rst(rst), .bclk(bclk), .fsync(fsync), .mode_sel(mode_sel),
        .tx_sample(tx_sample), .rx_in(rx_in), .tx_data(tx_data), .tx_oe(tx_oe),
        .rx_sample(rx_sample), .rx_valid(rx_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) if (rx_valid) begin
        pulses = pulses + 1;
        got = rx_sample;
    end

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // md: mode, w: sync width in rises, drop_a: sync falls with rise w instead of the low phase before it
    task automatic run_frame(input logic [1:0] md, input int w, input bit drop_a,
                             input logic [15:0] txw, input logic [15:0] rxw, input bit disturb);
        int start;
        int len;
        bit lng;
        string req;
        logic [15:0] exp_rx;
        lng = prev_long;
        len = (md == 2'b01) ? 16 : 8;
        case (md)
            2'b00: start = lng ? 0 : 1;
            2'b01: start = 1;
            2'b10: start = 1 + 8 * CHA;
            default: start = 1 + 8 * CHB;
        endcase
        req = (md == 2'b01) ? "R6" : (md[1] ? "R7" : (lng ? "R3/R2" : "R4/R2"));
        mode_sel = md;
        tx_sample = txw;
        pulses = 0;
        for (int k = 0; k < NK; k++) begin
            bit in_win;
            bit exp_d;
            int idx;
            in_win = (k >= start) && (k < start + len);
            idx = k - start;
            exp_d = 1'b0;
            if (in_win)
                exp_d = (len == 16) ? ((idx < 14) ? txw[15-idx] : 1'b0) : txw[7-idx];
            bclk = 1'b1;
            fsync = (k < w);
            @(negedge clk);
            chk(tx_oe == in_win, in_win ? req : "R8", {15'd0, tx_oe}, {15'd0, in_win});
            if (in_win)
                chk(tx_data == exp_d, req, {15'd0, tx_data}, {15'd0, exp_d});
            if (disturb && k == 0) begin
                tx_sample = ~txw;      // R10
                mode_sel = md ^ 2'b01; // R10
            end
            @(negedge clk);
            bclk = 1'b0;
            fsync = drop_a ? (k < w) : (k < w - 1);
            rx_in = in_win ? ((len == 16) ? rxw[15-idx] : rxw[7-idx]) : ~rxw[0];
            @(negedge clk);
            if (md == 2'b00 && lng && !drop_a && k == w - 1 && k == 7)
                chk(tx_oe == 1'b0, "R5", {15'd0, tx_oe}, 16'd0);
            @(negedge clk);
        end
        exp_rx = (len == 16) ? {rxw[15:2], 2'b00} : {8'h00, rxw[7:0]};
        chk(pulses == 1, "R9", 16'(pulses), 16'd1);
        chk(got == exp_rx, (len == 16) ? "R6" : "R9", got, exp_rx);
        prev_long = (w >= 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(tx_oe == 1'b0, "R1", {15'd0, tx_oe}, 16'd0);
        chk(rx_valid == 1'b0, "R1", {15'd0, rx_valid}, 16'd0);
        // R1: idle bit clocks without sync drive nothing
        for (int i = 0; i < 4; i++) begin
            bclk = 1'b1; @(negedge clk); @(negedge clk);
            chk(tx_oe == 1'b0, "R1", {15'd0, tx_oe}, 16'd0);
            bclk = 1'b0; @(negedge clk); @(negedge clk);
        end
        run_frame(2'b00, 1, 1'b0, 16'h00A5, 16'h003C, 1'b0);   // R4
        run_frame(2'b00, 3, 1'b0, 16'h005A, 16'h00C3, 1'b0);   // R2 short still
        run_frame(2'b00, 3, 1'b0, 16'h0081, 16'h007E, 1'b0);   // R3 long now
        run_frame(2'b00, 8, 1'b0, 16'h00F0, 16'h0011, 1'b1);   // R5 early, R10
        run_frame(2'b00, 8, 1'b1, 16'h0033, 16'h00EE, 1'b0);   // R5 coincident
        run_frame(2'b00, 12, 1'b0, 16'h00CC, 16'h0055, 1'b0);  // R5 ninth edge
        run_frame(2'b00, 1, 1'b0, 16'h0096, 16'h0069, 1'b0);   // R2 long applies
        run_frame(2'b00, 1, 1'b0, 16'h0007, 16'h00E0, 1'b0);   // R4
        for (int f = 0; f < 4; f++)
            run_frame(2'b01, 1, 1'b0, 16'hA5C3 ^ 16'(f * 16'h1357), 16'h3C96 + 16'(f * 16'h0F1F), f == 2);
        run_frame(2'b00, 4, 1'b0, 16'h0011, 16'h0022, 1'b0);
        run_frame(2'b01, 1, 1'b0, 16'hFFFF, 16'hFFFF, 1'b0);   // R6 after long
        run_frame(2'b10, 1, 1'b0, 16'h00B4, 16'h004B, 1'b0);   // R7
        run_frame(2'b11, 1, 1'b0, 16'h00D2, 16'h002D, 1'b1);   // R7, R10
        run_frame(2'b10, 1, 1'b0, 16'h1201, 16'h0080, 1'b0);   // R7
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            total++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
            $finish;
        end
    end
endmodule